// File: doc/BRIEF.md
# UART with Hardware Flow Control

This block is an asynchronous serial port: a transmitter and a receiver that share one system clock and one oversampling tick. The transmitter takes bytes through a one-entry holding register and sends them with a start bit, eight data bits and a stop bit. The receiver puts completed bytes into a small FIFO, and each entry carries its own framing-error bit. A one-cycle `tick_i` pulse paces the bit timing. Every bit lasts `OVS` ticks. Transmit bits change at the start of a bit period, which is the clock's falling phase. The receiver samples at mid-bit, the rising phase.

Flow control works in both directions. The transmitter starts a new character only while the clear-to-send input is asserted, and it always finishes a character it has started. The request-to-send output has three sources: a register bit, the receiver (it drops the output while the FIFO is full), or the transmitter (it raises the output while data is pending). Any edge on clear-to-send sets a sticky change flag. An interrupt line collects three maskable sources. A separate mask bit routes the FIFO-full condition to a DMA request line instead of the interrupt line. A loopback mode feeds the transmit stream into the receiver and holds the external pin idle.

Top module: `uart_fc`

## Requirements
- R1: `txd_o` is 1 whenever no character is being shifted out (idle, or disabled while idle) and at all times while `loop_i` is 1.
- R2: A frame is a start bit of 0, then 8 data bits with the least significant bit first, then a stop bit of 1. Each bit lasts `OVS` ticks (default 4).
- R3: The transmitter starts a new character only while the synchronized `cts_i` is 1. If `cts_i` falls during a character, that character still completes unchanged.
- R4: While `tx_en_i` is 0, no new character starts and a written byte stays pending. The byte is sent once `tx_en_i` returns to 1.
- R5: The receiver samples each bit at mid-bit. A start bit that is no longer 0 at its mid-point is rejected, and nothing is stored.
- R6: A stop bit sampled as 0 stores the byte with `rx_ferr_o` = 1. The receiver then waits for the line to return to 1 before it accepts a new start bit.
- R7: The receive FIFO holds 4 entries and delivers them in arrival order on `rx_data_o`; `rx_rd_i` pops the head. A byte that completes while the FIFO is full and is not read in that cycle is dropped and sets `overrun_o`. `overrun_o` stays set until `flag_clr_i` is pulsed.
- R8: Any change of the synchronized `cts_i`, rising or falling, sets `cts_delta_o`. `flag_clr_i` clears the flag. If a change and a clear fall in the same cycle, the flag stays set.
- R9: `irq_o` is the OR of these terms: `irq_mask_i[0]` AND `rx_avail_o`, `irq_mask_i[1]` AND `tx_ready_o`, and `irq_mask_i[2]` AND `cts_delta_o`. `irq_mask_i[3]` has no effect on `irq_o`.
- R10: `dma_req_o` is 1 exactly when `irq_mask_i[3]` is 1 and the FIFO is full (`rx_full_o`).
- R11: `rts_mode_i` selects the source of `rts_o`: 0 or 3 selects `rts_manual_i`, 1 selects receiver control, 2 selects transmitter control. Under receiver control, `rts_o` is 0 from the cycle after the FIFO becomes full. It returns to 1 in the cycle after a read leaves a free entry.
- R12: Under transmitter control, `rts_o` is 1 from the cycle after a byte is accepted. It returns to 0 after the last stop bit has been sent, provided no further byte is pending.
- R13: While `loop_i` is 1, the receiver takes the internal transmit stream and ignores `rxd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling enable, one pulse per 1/OVS bit |
| tx_en_i | input | 1 | Allows new characters to start |
| rx_en_i | input | 1 | Allows the receiver to accept start bits |
| loop_i | input | 1 | Internal loopback select |
| rts_mode_i | input | 2 | Source of rts_o (0/3 register, 1 receiver, 2 transmitter) |
| rts_manual_i | input | 1 | Register value of rts_o |
| irq_mask_i | input | 4 | [0] rx data, [1] tx ready, [2] CTS change, [3] full to DMA |
| flag_clr_i | input | 1 | Clears overrun_o and cts_delta_o |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | 8 | Byte to transmit |
| tx_ready_o | output | 1 | Holding register empty |
| rx_rd_i | input | 1 | Pop the FIFO head |
| rx_data_o | output | 8 | FIFO head byte |
| rx_ferr_o | output | 1 | Framing error of the FIFO head |
| rx_avail_o | output | 1 | FIFO not empty |
| rx_full_o | output | 1 | FIFO full |
| overrun_o | output | 1 | Sticky byte-dropped flag |
| cts_delta_o | output | 1 | Sticky CTS-change flag |
| rxd_i | input | 1 | Serial data in |
| cts_i | input | 1 | Clear to send, 1 = asserted |
| txd_o | output | 1 | Serial data out |
| rts_o | output | 1 | Request to send, 1 = asserted |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA service request |

## Verification
The CTS-change detector and the flag clear can act in the same cycle. The bench provokes this by pulsing `flag_clr_i` in the exact cycle the synchronized edge reaches the detector, which is two clocks after `cts_i` is driven. It then expects `cts_delta_o` to remain 1, because setting wins over clearing. A second collision is the DMA/interrupt split while the FIFO fills to its limit. The bench fills the FIFO with only `irq_mask_i[3]` set and expects `dma_req_o` high with `irq_o` low. It then reads one entry and expects both the request and the flow-control output to change.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
   typedef enum logic [1:0] {
      RTS_REG  = 2'd0,
      RTS_RXFC = 2'd1,
      RTS_TXFC = 2'd2,
      RTS_ALT  = 2'd3
   } rts_src_e;

   localparam int MSK_RXRDY = 0;
   localparam int MSK_TXRDY = 1;
   localparam int MSK_CTSCH = 2;
   localparam int MSK_FULL  = 3;
endpackage

// File: rtl/uart_fc_tx.sv
module uart_fc_tx #(
   parameter int DW  = 8,
   parameter int OVS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          en_i,
   input  logic          cts_i,
   input  logic          wr_i,
   input  logic [DW-1:0] wr_data_i,
   output logic          ready_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          line_o
);
   localparam int CW = $clog2(OVS);
   localparam int FW = DW + 2;
   localparam int BW = $clog2(FW);

   logic          hold_full;
   logic [DW-1:0] hold_q;
   logic [FW-1:0] shreg;
   logic [CW-1:0] phase;
   logic [BW-1:0] bitn;
   logic          busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_q    <= '0;
         shreg     <= '1;
         phase     <= '0;
         bitn      <= '0;
         busy      <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (wr_i && !hold_full) begin
            hold_full <= 1'b1;
            hold_q    <= wr_data_i;
         end
         if (tick_i) begin
            if (!busy && hold_full && cts_i && en_i) begin
               busy      <= 1'b1;
               shreg     <= {1'b1, hold_q, 1'b0};
               hold_full <= 1'b0;
               phase     <= '0;
               bitn      <= '0;
            end else if (busy) begin
               if (phase == CW'(OVS - 1)) begin
                  phase <= '0;
                  if (bitn == BW'(FW - 1)) begin
                     busy   <= 1'b0;
                     done_o <= 1'b1;
                  end else begin
                     bitn  <= bitn + 1'b1;
                     shreg <= {1'b1, shreg[FW-1:1]};
                  end
               end else begin
                  phase <= phase + 1'b1;
               end
            end
         end
      end
   end

   assign ready_o = !hold_full;
   assign busy_o  = busy;
   assign line_o  = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx #(
   parameter int DW  = 8,
   parameter int OVS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          en_i,
   input  logic          line_i,
   output logic          push_o,
   output logic [DW-1:0] data_o,
   output logic          ferr_o
);
   localparam int CW   = $clog2(OVS);
   localparam int BW   = $clog2(DW);
   localparam int HALF = OVS / 2;

   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_WAITHI} rx_st_e;

   rx_st_e        st;
   logic [CW-1:0] phase;
   logic [BW-1:0] bitn;
   logic [DW-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         phase  <= '0;
         bitn   <= '0;
         shreg  <= '0;
         push_o <= 1'b0;
         data_o <= '0;
         ferr_o <= 1'b0;
      end else begin
         push_o <= 1'b0;
         if (tick_i) begin
            unique case (st)
               S_IDLE: if (en_i && !line_i) begin
                  st    <= S_START;
                  phase <= '0;
               end
               S_START: if (phase == CW'(HALF - 1)) begin
                  phase <= '0;
                  bitn  <= '0;
                  st    <= line_i ? S_IDLE : S_DATA;
               end else begin
                  phase <= phase + 1'b1;
               end
               S_DATA: if (phase == CW'(OVS - 1)) begin
                  phase <= '0;
                  shreg <= {line_i, shreg[DW-1:1]};
                  if (bitn == BW'(DW - 1)) st <= S_STOP;
                  else bitn <= bitn + 1'b1;
               end else begin
                  phase <= phase + 1'b1;
               end
               S_STOP: if (phase == CW'(OVS - 1)) begin
                  phase  <= '0;
                  push_o <= 1'b1;
                  data_o <= shreg;
                  ferr_o <= !line_i;
                  st     <= line_i ? S_IDLE : S_WAITHI;
               end else begin
                  phase <= phase + 1'b1;
               end
               S_WAITHI: if (line_i) st <= S_IDLE;
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
   parameter int EW    = 9,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [EW-1:0] din_i,
   input  logic          pop_i,
   output logic [EW-1:0] dout_o,
   output logic          empty_o,
   output logic          full_o,
   output logic          drop_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int NW = AW + 1;

   logic [EW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [NW-1:0] count;
   logic          do_pop, do_push;

   assign empty_o = (count == '0);
   assign full_o  = (count == NW'(DEPTH));
   assign do_pop  = pop_i && !empty_o;
   assign do_push = push_i && (!full_o || do_pop);
   assign drop_o  = push_i && !do_push;
   assign dout_o  = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= din_i;
            wr_ptr      <= wr_ptr + 1'b1;
         end
         if (do_pop) rd_ptr <= rd_ptr + 1'b1;
         if (do_push && !do_pop) count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/uart_fc.sv
module uart_fc #(
   parameter int DW          = 8,
   parameter int OVS         = 4,
   parameter int FIFO_DEPTH  = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          tx_en_i,
   input  logic          rx_en_i,
   input  logic          loop_i,
   input  logic [1:0]    rts_mode_i,
   input  logic          rts_manual_i,
   input  logic [3:0]    irq_mask_i,
   input  logic          flag_clr_i,
   input  logic          tx_wr_i,
   input  logic [DW-1:0] tx_data_i,
   output logic          tx_ready_o,
   input  logic          rx_rd_i,
   output logic [DW-1:0] rx_data_o,
   output logic          rx_ferr_o,
   output logic          rx_avail_o,
   output logic          rx_full_o,
   output logic          overrun_o,
   output logic          cts_delta_o,
   input  logic          rxd_i,
   input  logic          cts_i,
   output logic          txd_o,
   output logic          rts_o,
   output logic          irq_o,
   output logic          dma_req_o
);
   import uart_fc_pkg::*;

   localparam int EW = DW + 1;

   initial begin
      if (OVS < 4 || (OVS % 2) != 0) $error("OVS must be even and at least 4");
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)
         $error("FIFO_DEPTH must be a power of two, at least 2");
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
      if (DW < 5) $error("DW must be at least 5");
   end

   logic [SYNC_STAGES-1:0] rxd_sync, cts_sync;
   logic rxd_s, cts_s, cts_prev;
   logic tx_line, tx_busy, tx_done, rx_line;
   logic rx_push, rx_ferr_new, fifo_empty, fifo_drop;
   logic [DW-1:0] rx_byte;
   logic [EW-1:0] fifo_head;
   logic rts_rx_q, rts_tx_q;
   rts_src_e rts_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxd_sync <= '1;
         cts_sync <= '0;
      end else begin
         rxd_sync <= {rxd_sync[SYNC_STAGES-2:0], rxd_i};
         cts_sync <= {cts_sync[SYNC_STAGES-2:0], cts_i};
      end
   end
   assign rxd_s = rxd_sync[SYNC_STAGES-1];
   assign cts_s = cts_sync[SYNC_STAGES-1];

   uart_fc_tx #(.DW(DW), .OVS(OVS)) i_tx (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(tx_en_i), .cts_i(cts_s),
      .wr_i(tx_wr_i), .wr_data_i(tx_data_i), .ready_o(tx_ready_o),
      .busy_o(tx_busy), .done_o(tx_done), .line_o(tx_line)
   );

   generate
      if (LOOPBACK_EN) begin : g_loop
         assign rx_line = loop_i ? tx_line : rxd_s;
         assign txd_o   = loop_i ? 1'b1 : tx_line;
      end else begin : g_noloop
         logic unused_loop;
         assign unused_loop = loop_i;
         assign rx_line     = rxd_s;
         assign txd_o       = tx_line;
      end
   endgenerate

   uart_fc_rx #(.DW(DW), .OVS(OVS)) i_rx (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(rx_en_i), .line_i(rx_line),
      .push_o(rx_push), .data_o(rx_byte), .ferr_o(rx_ferr_new)
   );

   uart_fc_fifo #(.EW(EW), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(rx_push), .din_i({rx_ferr_new, rx_byte}),
      .pop_i(rx_rd_i), .dout_o(fifo_head), .empty_o(fifo_empty),
      .full_o(rx_full_o), .drop_o(fifo_drop)
   );

   assign rx_data_o  = fifo_head[DW-1:0];
   assign rx_ferr_o  = fifo_head[DW];
   assign rx_avail_o = !fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cts_prev    <= 1'b0;
         cts_delta_o <= 1'b0;
         overrun_o   <= 1'b0;
         rts_rx_q    <= 1'b1;
         rts_tx_q    <= 1'b0;
      end else begin
         cts_prev <= cts_s;
         if (cts_s != cts_prev) cts_delta_o <= 1'b1;
         else if (flag_clr_i)   cts_delta_o <= 1'b0;
         if (fifo_drop)         overrun_o <= 1'b1;
         else if (flag_clr_i)   overrun_o <= 1'b0;
         rts_rx_q <= !rx_full_o;
         if (tx_wr_i && tx_ready_o)      rts_tx_q <= 1'b1;
         else if (tx_done && tx_ready_o) rts_tx_q <= 1'b0;
      end
   end

   assign rts_src = rts_src_e'(rts_mode_i);
   always_comb begin
      unique case (rts_src)
         RTS_RXFC: rts_o = rts_rx_q;
         RTS_TXFC: rts_o = rts_tx_q;
         default:  rts_o = rts_manual_i;
      endcase
   end

   assign irq_o = (irq_mask_i[MSK_RXRDY] && rx_avail_o) ||
                  (irq_mask_i[MSK_TXRDY] && tx_ready_o) ||
                  (irq_mask_i[MSK_CTSCH] && cts_delta_o);
   assign dma_req_o = irq_mask_i[MSK_FULL] && rx_full_o;
endmodule

// File: rtl/uart_fc_chk.sv
module uart_fc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       loop_i,
   input logic       tx_busy,
   input logic       txd_o,
   input logic       cts_s,
   input logic       cts_prev,
   input logic       rx_push,
   input logic       rx_full_o,
   input logic       rx_rd_i,
   input logic       overrun_o,
   input logic       cts_delta_o,
   input logic [3:0] irq_mask_i,
   input logic       dma_req_o,
   input logic [1:0] rts_mode_i,
   input logic       rts_o
);
   a_r1_mark_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_busy || loop_i) |-> txd_o);

   a_r3_start_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(cts_s));

   a_r7_overrun_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full_o && !rx_rd_i) |=> overrun_o);

   a_r8_delta_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_s != cts_prev) |=> cts_delta_o);

   a_r10_dma_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_mask_i[3] |-> !dma_req_o);

   a_r11_rts_drops_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      (rts_mode_i == 2'd1 && rx_full_o) |=> (rts_mode_i != 2'd1 || !rts_o));
endmodule

bind uart_fc uart_fc_chk i_chk (
   .clk(clk), .rst_n(rst_n), .loop_i(loop_i), .tx_busy(tx_busy), .txd_o(txd_o),
   .cts_s(cts_s), .cts_prev(cts_prev), .rx_push(rx_push), .rx_full_o(rx_full_o),
   .rx_rd_i(rx_rd_i), .overrun_o(overrun_o), .cts_delta_o(cts_delta_o),
   .irq_mask_i(irq_mask_i), .dma_req_o(dma_req_o), .rts_mode_i(rts_mode_i),
   .rts_o(rts_o)
);

// File: tb/test_uart_fc.sv
`timescale 1ns/1ps
module test_uart_fc;
   localparam int BITCLK = 8;  // OVS 4 ticks, one tick every 2 clocks

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, tick, tx_en, rx_en, loop_en, rts_man, flag_clr, tx_wr, rx_rd, rxd, cts;
   logic [1:0] rts_mode;
   logic [3:0] mask;
   logic [7:0] tx_data, rx_data;
   logic tx_ready, rx_ferr, rx_avail, rx_full, overrun, cts_delta, txd, rts, irq, dma;

   int checks = 0, errors = 0;
   bit finished = 0;
   bit mon_en = 0;

   uart_fc i_uart_fc (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .tx_en_i(tx_en), .rx_en_i(rx_en),
      .loop_i(loop_en), .rts_mode_i(rts_mode), .rts_manual_i(rts_man),
      .irq_mask_i(mask), .flag_clr_i(flag_clr), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
      .tx_ready_o(tx_ready), .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_ferr_o(rx_ferr),
      .rx_avail_o(rx_avail), .rx_full_o(rx_full), .overrun_o(overrun),
      .cts_delta_o(cts_delta), .rxd_i(rxd), .cts_i(cts), .txd_o(txd), .rts_o(rts),
      .irq_o(irq), .dma_req_o(dma)
   );

   always @(negedge clk) tick <= (rst_n === 1'b1) ? ~tick : 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // reference model compared on every clock: interrupt/request composition and loopback mark
   always @(negedge clk) if (mon_en && !finished) begin
      chk(irq === ((mask[0] & rx_avail) | (mask[1] & tx_ready) | (mask[2] & cts_delta)),
          "R9 irq composition", irq, (mask[0] & rx_avail) | (mask[1] & tx_ready) | (mask[2] & cts_delta));
      chk(dma === (mask[3] & rx_full), "R10 dma request", dma, mask[3] & rx_full);
      if (loop_en) chk(txd === 1'b1, "R1 mark during loopback", txd, 1);
   end

   task automatic send(input logic [7:0] b, input bit stop);
      rxd = 1'b0; repeat (BITCLK) @(negedge clk);
      for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (BITCLK) @(negedge clk); end
      rxd = stop; repeat (BITCLK) @(negedge clk);
      rxd = 1'b1; repeat (BITCLK) @(negedge clk);
   endtask

   task automatic read_exp(input logic [7:0] b, input bit fe, input string req);
      chk(rx_avail === 1'b1, req, rx_avail, 1);
      chk(rx_data === b, req, rx_data, b);
      chk(rx_ferr === fe, req, rx_ferr, fe);
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
   endtask

   task automatic write(input logic [7:0] b);
      tx_data = b; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic capture(output logic [7:0] b, input bit drop);
      int t = 0;
      b = 'x;
      while (txd !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
      repeat (BITCLK/2) @(negedge clk);
      chk(txd === 1'b0, "R2 start bit low", txd, 0);
      if (drop) cts = 1'b0;
      for (int i = 0; i < 8; i++) begin repeat (BITCLK) @(negedge clk); b[i] = txd; end
      repeat (BITCLK) @(negedge clk);
      chk(txd === 1'b1, "R2 stop bit high", txd, 1);
   endtask

   task automatic mark_for(input int n, input string req);
      bit ok = 1;
      for (int i = 0; i < n; i++) begin if (txd !== 1'b1) ok = 0; @(negedge clk); end
      chk(ok, req, ok, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] got;
      rst_n = 0; tick = 0; tx_en = 1; rx_en = 1; loop_en = 0; rts_mode = 0; rts_man = 0;
      mask = 0; flag_clr = 0; tx_wr = 0; tx_data = 0; rx_rd = 0; rxd = 1; cts = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      mon_en = 1;
      chk(txd === 1'b1, "R1 reset txd mark", txd, 1);
      chk(rx_avail === 1'b0 && overrun === 1'b0, "R7 reset fifo empty", rx_avail, 0);
      chk(rts === 1'b0, "R11 manual rts low", rts, 0);
      rts_man = 1; @(negedge clk);
      chk(rts === 1'b1, "R11 manual rts high", rts, 1);
      rts_mode = 2'd3; @(negedge clk);
      chk(rts === 1'b1, "R11 mode 3 uses register", rts, 1);
      rts_mode = 0;

      // receive, lsb first, in order
      send(8'hA5, 1);
      read_exp(8'hA5, 0, "R2 R5 receive A5");
      send(8'h3C, 1); send(8'h01, 1);
      read_exp(8'h3C, 0, "R7 order first"); read_exp(8'h01, 0, "R7 order second");

      // start-bit glitch rejected
      rxd = 0; repeat (2) @(negedge clk); rxd = 1;
      repeat (120) @(negedge clk);
      chk(rx_avail === 1'b0, "R5 glitch rejected", rx_avail, 0);

      // framing error then recovery
      send(8'h7E, 0);
      read_exp(8'h7E, 1, "R6 framing error flagged");
      send(8'h42, 1);
      read_exp(8'h42, 0, "R6 recovery after break");

      // transmit
      cts = 1; repeat (6) @(negedge clk);
      write(8'h96); capture(got, 0);
      chk(got === 8'h96, "R2 transmit 96 lsb first", got, 8'h96);

      // CTS blocks start
      cts = 0; repeat (6) @(negedge clk);
      write(8'hC3);
      mark_for(150, "R3 no start without cts");
      cts = 1; capture(got, 0);
      chk(got === 8'hC3, "R3 sends after cts", got, 8'hC3);

      // CTS drop mid character
      repeat (10) @(negedge clk);
      write(8'h5B); capture(got, 1);
      chk(got === 8'h5B, "R3 in-progress char completes", got, 8'h5B);
      repeat (20) @(negedge clk);

      // transmitter disabled
      tx_en = 0; cts = 1;
      repeat (6) @(negedge clk);
      write(8'h11);
      mark_for(150, "R4 R1 disabled holds mark");
      chk(tx_ready === 1'b0, "R4 byte pending", tx_ready, 0);
      tx_en = 1; capture(got, 0);
      chk(got === 8'h11, "R4 sent after enable", got, 8'h11);
      repeat (20) @(negedge clk);

      // CTS change flag and interrupt routing
      flag_clr = 1; @(negedge clk); flag_clr = 0;
      chk(cts_delta === 1'b0, "R8 flag cleared", cts_delta, 0);
      cts = 0; repeat (4) @(negedge clk);
      chk(cts_delta === 1'b1, "R8 falling edge sets flag", cts_delta, 1);
      mask = 4'b0100; @(negedge clk);
      chk(irq === 1'b1, "R9 cts change interrupt", irq, 1);
      flag_clr = 1; @(negedge clk); flag_clr = 0;
      chk(cts_delta === 1'b0 && irq === 1'b0, "R9 cleared flag drops irq", irq, 0);
      cts = 1; @(negedge clk); @(negedge clk);
      flag_clr = 1; @(negedge clk); flag_clr = 0;
      chk(cts_delta === 1'b1, "R8 set wins over clear", cts_delta, 1);
      flag_clr = 1; @(negedge clk); flag_clr = 0;
      mask = 4'b0010; @(negedge clk);
      chk(irq === 1'b1, "R9 tx ready interrupt", irq, 1);
      mask = 4'b1001; @(negedge clk);
      chk(irq === 1'b0, "R9 empty fifo no irq", irq, 0);
      mask = 0;

      // loopback
      loop_en = 1; rxd = 0;
      repeat (4) @(negedge clk);
      write(8'h5A);
      mark_for(140, "R1 R13 pin idle in loopback");
      read_exp(8'h5A, 0, "R13 loopback data");
      chk(rx_avail === 1'b0, "R13 rxd ignored", rx_avail, 0);
      rxd = 1; repeat (6) @(negedge clk); loop_en = 0;
      repeat (6) @(negedge clk);

      // RTS under transmitter control
      rts_mode = 2'd2; @(negedge clk);
      chk(rts === 1'b0, "R12 idle rts low", rts, 0);
      write(8'h77); @(negedge clk);
      chk(rts === 1'b1, "R12 rts after write", rts, 1);
      capture(got, 0);
      chk(got === 8'h77, "R12 data sent", got, 8'h77);
      repeat (16) @(negedge clk);
      chk(rts === 1'b0, "R12 rts after stop", rts, 0);

      // fill, overrun, DMA request, RTS under receiver control
      rts_mode = 2'd1; mask = 4'b1000; @(negedge clk);
      chk(rts === 1'b1, "R11 receiver rts high when room", rts, 1);
      for (int i = 0; i < 4; i++) send(8'h10 + 8'(i), 1);
      chk(rx_full === 1'b1, "R7 four entries full", rx_full, 1);
      chk(rts === 1'b0, "R11 rts low when full", rts, 0);
      chk(dma === 1'b1 && irq === 1'b0, "R10 full routed to dma", dma, 1);
      send(8'h14, 1);
      chk(overrun === 1'b1, "R7 overrun set", overrun, 1);
      read_exp(8'h10, 0, "R7 head kept");
      @(negedge clk);
      chk(rts === 1'b1, "R11 rts back after read", rts, 1);
      chk(dma === 1'b0, "R10 dma drops", dma, 0);
      read_exp(8'h11, 0, "R7 entry 2");
      read_exp(8'h12, 0, "R7 entry 3");
      read_exp(8'h13, 0, "R7 entry 4");
      chk(rx_avail === 1'b0, "R7 overrun byte discarded", rx_avail, 0);
      chk(overrun === 1'b1, "R7 overrun sticky", overrun, 1);
      flag_clr = 1; @(negedge clk); flag_clr = 0;
      chk(overrun === 1'b0, "R7 overrun cleared", overrun, 0);

      mon_en = 0;
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule